// File: doc/BRIEF.md
# SPI Interrupt Status and Enable Logic

This block gathers the interrupt sources of a serial peripheral controller into one interrupt line. It holds three registers: a 32-bit status word, a 32-bit per-bit enable mask and a single global enable bit. Single-cycle event pulses from the shifter set status bits directly. Two level flags from the receive FIFO, "holds data" and "full", are folded into the status word each time the register file is accessed. Software clears or sets status bits by writing a mask that flips them.

The register port is a simple strobe interface. A write takes one cycle. A read returns its data on `rd_data` one clock after the strobe. The interrupt line is a flop. It reflects the status, mask and global enable as they stood one clock earlier.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset, the status word, the enable mask and the global enable are all zero, and `irq` and `rd_data` are 0.
- R2: A read at byte offset 0x1C, 0x20 or 0x28 returns, on `rd_data` one clock after the strobe, the global enable (as bit 31, all other bits 0), the status word or the enable mask, respectively, as held before the access. A read at any other offset returns 0.
- R3: A write at 0x28 stores all 32 bits of the enable mask. A write at 0x1C stores only data bit 31 as the global enable. A write at any other offset leaves all three registers unchanged.
- R4: A write at 0x20 inverts every status bit whose data bit is 1 and leaves every status bit whose data bit is 0 unchanged.
- R5: The event pulses set status bits and those bits stay set until software flips them. The mapping is: transmit empty to bit 2, transmit underrun to bit 3, receive overrun to bit 5, transmit half empty to bit 6. Each bit is set in the clock after its pulse.
- R6: The receive-has-data flag sets status bit 8 and the receive-full flag sets status bit 4. Both are applied only on a re-evaluation: a read cycle, a write cycle, or the first cycle after reset. They are never cleared by this rule, and a flag that rises and falls between accesses leaves no trace.
- R7: An event pulse that arrives in the same cycle as a status write that flips its bit leaves that bit set.
- R8: `irq` is 1 exactly when, one clock earlier, the global enable was set and the status word AND the enable mask was nonzero.
- R9: When a receive level flag is high during a status write that flips its bit, the bit is set again by the re-evaluation that follows the write, so it remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid one clock after `rd_en` |
| ev_tx_empty | input | 1 | Pulse: transmit register drained |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| ev_rx_overrun | input | 1 | Pulse: receive overrun |
| ev_tx_half | input | 1 | Pulse: transmit FIFO half empty |
| rx_has_data | input | 1 | Level: receive FIFO not empty |
| rx_full | input | 1 | Level: receive FIFO full |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- the global enable gates `irq`, and an enabled pending bit always drives it;
- an event pulse always lands in its status bit;
- a status write flips a hardware-free bit as required;
- a receive level present at an access is always captured;
- the status word never moves when there is no access and no event.

Some behaviours only the directed scenarios can show. These are: the exact read-back values and the read latency, the one-clock lag of `irq`, and the fact that a level flag is ignored between accesses. The same holds for the two same-cycle collisions: a toggle write against an event, and a toggle write against a level re-evaluation.

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int GIE_OFS  = 'h1C,
  parameter int STAT_OFS = 'h20,
  parameter int EN_OFS   = 'h28,
  parameter int GIE_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              ev_tx_empty,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_half,
  input  logic              rx_has_data,
  input  logic              rx_full,
  output logic              irq
);

  localparam int B_TX_EMPTY = 2;
  localparam int B_TX_UNDER = 3;
  localparam int B_RX_FULL  = 4;
  localparam int B_RX_OVER  = 5;
  localparam int B_TX_HALF  = 6;
  localparam int B_RX_DATA  = 8;

  logic [31:0] stat_q, en_q, stat_d, ev_bits, lvl_bits, rd_mux;
  logic        gie_q, first_q, reeval;
  logic        sel_gie, sel_stat, sel_en;

  assign sel_gie  = addr == ADDR_W'(GIE_OFS);
  assign sel_stat = addr == ADDR_W'(STAT_OFS);
  assign sel_en   = addr == ADDR_W'(EN_OFS);
  assign reeval   = wr_en | rd_en | first_q;

  always_comb begin
    ev_bits = '0;
    ev_bits[B_TX_EMPTY] = ev_tx_empty;
    ev_bits[B_TX_UNDER] = ev_tx_underrun;
    ev_bits[B_RX_OVER]  = ev_rx_overrun;
    ev_bits[B_TX_HALF]  = ev_tx_half;
    lvl_bits = '0;
    lvl_bits[B_RX_DATA] = rx_has_data;
    lvl_bits[B_RX_FULL] = rx_full;
  end

  always_comb begin
    stat_d = stat_q;
    if (wr_en && sel_stat) stat_d = stat_d ^ wr_data;
    if (reeval) stat_d = stat_d | lvl_bits;
    stat_d = stat_d | ev_bits;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_gie) rd_mux[GIE_BIT] = gie_q;
    else if (sel_stat) rd_mux = stat_q;
    else if (sel_en) rd_mux = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      gie_q   <= 1'b0;
      first_q <= 1'b1;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      first_q <= 1'b0;
      stat_q  <= stat_d;
      if (wr_en && sel_en) en_q <= wr_data;
      if (wr_en && sel_gie) gie_q <= wr_data[GIE_BIT];
      if (rd_en) rd_data <= rd_mux;
      irq <= gie_q && (|(stat_q & en_q));
    end
  end

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !irq);
  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_q && (|(stat_q & en_q))) |=> irq);
  p_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_empty |=> stat_q[B_TX_EMPTY]);
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_stat) |=> stat_q[7] == ($past(stat_q[7]) ^ $past(wr_data[7])));
  p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reeval && rx_has_data) |=> stat_q[B_RX_DATA]);
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reeval && !(|ev_bits)) |=> $stable(stat_q));

endmodule

// File: tb/spi_irq_ctrl_test.sv
module spi_irq_ctrl_test;
  localparam logic [7:0] A_GIE = 8'h1C, A_STAT = 8'h20, A_EN = 8'h28;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic ev_tx_empty = 0, ev_tx_underrun = 0, ev_rx_overrun = 0, ev_tx_half = 0;
  logic rx_has_data = 0, rx_full = 0, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_irq_ctrl uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic pulse_all(logic e0, logic e1, logic e2, logic e3);
    @(negedge clk);
    ev_tx_empty = e0; ev_tx_underrun = e1; ev_rx_overrun = e2; ev_tx_half = e3;
    @(negedge clk);
    ev_tx_empty = 0; ev_tx_underrun = 0; ev_rx_overrun = 0; ev_tx_half = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rd_data", rd_data, 0);
    rd(A_STAT, d); check("R1 status", d, 0);
    rd(A_EN, d);   check("R1 enable", d, 0);
    rd(A_GIE, d);  check("R1 gie", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_EN, 32'hA5A5_0F0F);
    rd(A_EN, d); check("R3 enable full width", d, 32'hA5A5_0F0F);
    check("R2 read holds", rd_data, 32'hA5A5_0F0F);
    wr(A_GIE, 32'hFFFF_FFFF);
    rd(A_GIE, d); check("R2 gie bit31 only", d, 32'h8000_0000);
    wr(A_GIE, 32'h7FFF_FFFF);
    rd(A_GIE, d); check("R3 gie from bit31", d, 0);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, d); check("R2 unmapped read", d, 0);
    rd(A_EN, d);  check("R3 unmapped write ignored en", d, 32'hA5A5_0F0F);
    rd(A_STAT, d); check("R3 unmapped write ignored stat", d, 0);
    rd(A_GIE, d); check("R3 unmapped write ignored gie", d, 0);
  endtask

  task automatic t_toggle();
    logic [31:0] d;
    wr(A_STAT, 32'h0000_0081);
    rd(A_STAT, d); check("R4 toggle set", d, 32'h81);
    wr(A_STAT, 32'h0000_0001);
    rd(A_STAT, d); check("R4 toggle clear one", d, 32'h80);
    wr(A_STAT, 32'h0000_0080);
    rd(A_STAT, d); check("R4 toggle clear all", d, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse_all(1, 0, 0, 0);
    check("R5 tx empty next clock", {31'b0, uut.stat_q[2]}, 1);
    repeat (3) @(negedge clk);
    rd(A_STAT, d); check("R5 tx empty sticky", d, 32'h4);
    pulse_all(0, 1, 1, 1);
    rd(A_STAT, d); check("R5 other events", d, 32'h6C);
    wr(A_STAT, 32'h6C);
    rd(A_STAT, d); check("R5 cleared by toggle", d, 0);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    @(negedge clk); rx_has_data = 1;
    repeat (3) @(negedge clk);
    rx_has_data = 0;
    rd(A_STAT, d); check("R6 level ignored between accesses", d, 0);
    rx_has_data = 1;
    rd(A_STAT, d); check("R6 read returns pre-eval", d, 0);
    rd(A_STAT, d); check("R6 read sets bit8", d, 32'h100);
    rx_has_data = 0;
    rd(A_STAT, d); check("R6 never cleared by level", d, 32'h100);
    wr(A_STAT, 32'h100);
    rd(A_STAT, d); check("R6 cleared when level low", d, 0);
    rx_full = 1;
    wr(A_EN, 32'hA5A5_0F0F);
    rx_full = 0;
    rd(A_STAT, d); check("R6 write sets bit4", d, 32'h10);
    wr(A_STAT, 32'h10);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    rx_full = 1;
    wr(A_STAT, 32'h10);
    rd(A_STAT, d); check("R9 toggle set with level", d, 32'h10);
    wr(A_STAT, 32'h10);
    rd(A_STAT, d); check("R9 toggle clear re-set by level", d, 32'h10);
    rx_full = 0;
    wr(A_STAT, 32'h10);
    rd(A_STAT, d); check("R9 clears once level low", d, 0);
    pulse_all(1, 0, 0, 0);
    @(negedge clk); wr_en = 1; addr = A_STAT; wr_data = 32'h4; ev_tx_empty = 1;
    @(negedge clk); wr_en = 0; ev_tx_empty = 0;
    rd(A_STAT, d); check("R7 event beats toggle", d, 32'h4);
  endtask

  task automatic t_irq();
    wr(A_EN, 32'h4);
    wr(A_GIE, 32'h8000_0000);
    check("R8 irq one clock late", {31'b0, irq}, 0);
    @(negedge clk); check("R8 irq asserted", {31'b0, irq}, 1);
    wr(A_GIE, 0);
    check("R8 irq before gie drop seen", {31'b0, irq}, 1);
    @(negedge clk); check("R8 irq gated by gie", {31'b0, irq}, 0);
    wr(A_GIE, 32'h8000_0000);
    wr(A_EN, 32'hFFFF_FFFB);
    @(negedge clk); check("R8 irq masked", {31'b0, irq}, 0);
    wr(A_EN, 32'h4);
    @(negedge clk); check("R8 irq re-enabled", {31'b0, irq}, 1);
    wr(A_STAT, 32'h4);
    @(negedge clk); check("R8 irq after status clear", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_toggle();
    t_events();
    t_levels();
    t_collide();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule